// File: doc/BRIEF.md
# Chained converter readback controller

This block is the host-side controller for a string of serial analog-to-digital converters wired output-to-input, so that the whole string acts as one long shift register. A one-cycle request starts a conversion on every converter at once. The controller holds the serial clock high as it raises the start line. This puts the converters into chained operation with an end-of-conversion indication on the data line. The start line then stays high while the controller waits for the data line from the nearest converter to go high.

That low-to-high transition means every converter in the string has finished. The controller then emits one burst of serial clock pulses, and the count covers every converter in the string. It samples the returning data at each falling clock edge and drops the first sample, which is the high marker. It splits the rest into one word per converter and presents all the words at once on a parallel bus with a one-cycle done strobe. If the marker never arrives within a set window, the controller ends the attempt and raises an error flag instead.

The number of converters, the word width, the serial clock divider, the timeout window and the input synchroniser depth are parameters. The serial clock is made from the system clock: each high and each low phase lasts CLK_DIV system cycles.

Top module: `chain_rdbk_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, cnv_o is low and sck_o is high. A start_i pulse in the idle state makes cnv_o rise on the next clock edge, and sck_o is high in that cycle.
- R2: Once raised, cnv_o stays high without a break until the readback or the timeout ends. sck_o is low only while cnv_o is high.
- R3: No serial clock pulse is issued before the synchronised sdo_i has gone from low to high while cnv_o is high.
- R4: A readback issues exactly NUM_DEV*WORD_W+1 falling edges on sck_o. Every low phase lasts CLK_DIV system cycles, and so does every high phase between two falling edges.
- R5: sdo_i is sampled when sck_o falls, and the first sample is thrown away. The next NUM_DEV*WORD_W samples arrive MSB first, with the nearest converter's word first. Word k (k = 0 for the nearest converter) is placed at words_o[k*WORD_W +: WORD_W].
- R6: At the end of the last low phase, sck_o returns high and cnv_o falls in the same cycle. done_o is high for that one cycle only, and words_o then holds the new words until the next done_o.
- R7: start_i has no effect while a conversion wait or a readback is in progress: there is no extra rise of cnv_o and no restart.
- R8: If the marker has not arrived after cnv_o has been high for TIMEOUT_CYC cycles, cnv_o falls and err_o rises in the same cycle, and done_o is not asserted. err_o stays high until the next accepted start_i clears it.
- R9: Synchronous active-high reset leaves done_o low, err_o low and words_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to convert and read the string |
| sdo_i | input | 1 | Serial data from the nearest converter (asynchronous) |
| cnv_o | output | 1 | Conversion start line to all converters |
| sck_o | output | 1 | Serial clock to all converters |
| words_o | output | NUM_DEV*WORD_W | All converter words, word k at bits k*WORD_W and up |
| done_o | output | 1 | One-cycle strobe: words_o updated |
| err_o | output | 1 | Sticky flag: end-of-conversion marker timed out |

## Verification
The bench builds the controller with three converters of 18 bits, CLK_DIV of 2 and a 300-cycle timeout. Three converters are enough to check the word order and the 55-pulse burst count. A divider of 2 is the smallest that still gives the two-stage synchroniser time to settle before the next falling edge, so the sampling margin is at its tightest. The short timeout lets the bench cover both the timeout path and the recovery after it within the cycle limit. A behavioural model of the converter string answers each transaction from a bit queue, and the bench compares the clock phases, the line order and the words against it on every cycle.

// File: rtl/chain_rdbk_pkg.sv
package chain_rdbk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/chain_sync.sv
// Multi-stage synchroniser for the asynchronous serial data input.
module chain_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[gi] <= 1'b0;
        else     stage_q[gi] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[gi] <= 1'b0;
        else     stage_q[gi] <= stage_q[gi-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/chain_sck_gen.sv
// Burst serial clock: idles high, PULSES low phases, each phase CLK_DIV cycles.
module chain_sck_gen #(
  parameter int PULSES  = 55,
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic sck_o,
  output logic fall_o,
  output logic end_o
);
  localparam int CNT_W = $clog2(CLK_DIV + 1);
  localparam int PC_W  = $clog2(PULSES + 1);

  logic             active_q;
  logic             sck_q;
  logic [CNT_W-1:0] phase_q;
  logic [PC_W-1:0]  pulse_q;
  logic             phase_end;

  assign phase_end = active_q && (phase_q == '0);
  assign fall_o    = phase_end && sck_q;
  assign end_o     = phase_end && !sck_q && (pulse_q == PC_W'(PULSES));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sck_q    <= 1'b1;
      phase_q  <= '0;
      pulse_q  <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      sck_q    <= 1'b1;
      phase_q  <= CNT_W'(CLK_DIV - 1);
      pulse_q  <= '0;
    end else if (phase_end) begin
      phase_q <= CNT_W'(CLK_DIV - 1);
      if (sck_q) begin
        sck_q   <= 1'b0;
        pulse_q <= pulse_q + 1'b1;
      end else begin
        sck_q <= 1'b1;
        if (pulse_q == PC_W'(PULSES)) active_q <= 1'b0;
      end
    end else if (active_q) begin
      phase_q <= phase_q - 1'b1;
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/chain_word_asm.sv
// Collects serial samples, drops the first (marker), reorders words.
module chain_word_asm #(
  parameter int NUM_DEV = 3,
  parameter int WORD_W  = 18
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_i,
  input  logic                      bit_vld_i,
  input  logic                      bit_i,
  output logic [NUM_DEV*WORD_W-1:0] words_o
);
  localparam int DATA_BITS = NUM_DEV * WORD_W;

  logic                 skip_q;
  logic [DATA_BITS-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q  <= 1'b1;
      shreg_q <= '0;
    end else if (clr_i) begin
      skip_q <= 1'b1;
    end else if (bit_vld_i) begin
      if (skip_q) skip_q  <= 1'b0;
      else        shreg_q <= {shreg_q[DATA_BITS-2:0], bit_i};
    end
  end

  // First word received ends in the top slice; map it to slot 0.
  for (genvar k = 0; k < NUM_DEV; k++) begin : g_word
    assign words_o[k*WORD_W +: WORD_W] = shreg_q[(NUM_DEV-1-k)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/chain_rdbk_ctrl.sv
module chain_rdbk_ctrl
  import chain_rdbk_pkg::*;
#(
  parameter int NUM_DEV     = 3,
  parameter int WORD_W      = 18,
  parameter int CLK_DIV     = 2,
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      sdo_i,
  output logic                      cnv_o,
  output logic                      sck_o,
  output logic [NUM_DEV*WORD_W-1:0] words_o,
  output logic                      done_o,
  output logic                      err_o
);
  localparam int DATA_BITS = NUM_DEV * WORD_W;
  localparam int PULSES    = DATA_BITS + 1;
  localparam int TMO_W     = $clog2(TIMEOUT_CYC + 1);

  ctl_state_t           state_q;
  logic                 sdo_s;
  logic                 sdo_prev_q;
  logic                 sdo_rise;
  logic                 burst_go;
  logic                 bit_fall;
  logic                 burst_end;
  logic                 asm_clr;
  logic [TMO_W-1:0]     tmo_q;
  logic [DATA_BITS-1:0] asm_words;

  chain_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (sdo_i),
    .q_o (sdo_s)
  );

  assign sdo_rise = sdo_s && !sdo_prev_q;
  assign burst_go = (state_q == ST_CONV) && sdo_rise;
  assign asm_clr  = (state_q == ST_IDLE) && start_i;

  chain_sck_gen #(.PULSES(PULSES), .CLK_DIV(CLK_DIV)) sck_i (
    .clk    (clk),
    .rst    (rst),
    .go_i   (burst_go),
    .sck_o  (sck_o),
    .fall_o (bit_fall),
    .end_o  (burst_end)
  );

  chain_word_asm #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) asm_i (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (asm_clr),
    .bit_vld_i (bit_fall),
    .bit_i     (sdo_s),
    .words_o   (asm_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnv_o      <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      tmo_q      <= '0;
      words_o    <= '0;
      sdo_prev_q <= 1'b0;
    end else begin
      sdo_prev_q <= sdo_s;
      done_o     <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CONV;
            cnv_o   <= 1'b1;
            err_o   <= 1'b0;
            tmo_q   <= '0;
          end
        end
        ST_CONV: begin
          if (sdo_rise) begin
            state_q <= ST_SHIFT;
          end else if (tmo_q == TMO_W'(TIMEOUT_CYC - 1)) begin
            state_q <= ST_IDLE;
            cnv_o   <= 1'b0;
            err_o   <= 1'b1;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (burst_end) begin
            state_q <= ST_IDLE;
            cnv_o   <= 1'b0;
            done_o  <= 1'b1;
            words_o <= asm_words;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_rdbk_chk.sv
module chain_rdbk_chk #(
  parameter int TOTAL = 55
) (
  input logic clk,
  input logic rst,
  input logic cnv_o,
  input logic sck_o,
  input logic done_o,
  input logic err_o
);
  logic        sck_p;
  logic        cnv_p;
  logic [15:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p    <= 1'b1;
      cnv_p    <= 1'b0;
      fall_cnt <= '0;
    end else begin
      sck_p <= sck_o;
      cnv_p <= cnv_o;
      if (cnv_o && !cnv_p)      fall_cnt <= '0;
      else if (sck_p && !sck_o) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  AST_START_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> sck_o); // R1
  AST_SCK_ONLY_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    !sck_o |-> cnv_o); // R2
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (fall_cnt == 16'(TOTAL))); // R4
  AST_DONE_ENDS_CNV: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cnv_o && $past(cnv_o) && sck_o)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> ($fell(cnv_o) && !done_o)); // R8
endmodule

bind chain_rdbk_ctrl chain_rdbk_chk #(.TOTAL(NUM_DEV*WORD_W+1)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .cnv_o  (cnv_o),
  .sck_o  (sck_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/chain_rdbk_ctrl_tb_top.sv
`timescale 1ns/1ps
module chain_rdbk_ctrl_tb_top;
  localparam int NUM_DEV     = 3;
  localparam int WORD_W      = 18;
  localparam int CLK_DIV     = 2;
  localparam int TIMEOUT_CYC = 300;
  localparam int CONV_LAT    = 40;
  localparam int DATA_BITS   = NUM_DEV * WORD_W;
  localparam int PULSES      = DATA_BITS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sdo_r = 1'b0;
  logic cnv_o, sck_o, done_o, err_o;
  logic [DATA_BITS-1:0] words_o;

  always #5 clk = ~clk;

  chain_rdbk_ctrl #(
    .NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .CLK_DIV(CLK_DIV),
    .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sdo_i(sdo_r),
    .cnv_o(cnv_o), .sck_o(sck_o), .words_o(words_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  function automatic void chk(input bit ok, input string req,
                              input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endfunction

  // Behavioural model of the converter string and per-cycle comparison
  logic [DATA_BITS-1:0] exp_words = '0;
  bit   q_bits[$];
  bit   respond = 1;
  bit   expect_tmo = 0;
  bit   marker_seen = 0;
  int   conv_timer = -1;
  int   fall_cnt = 0, cnv_len = 0, run_len = 0;
  int   done_cnt = 0, rise_cnt = 0, tmo_cnt = 0;
  logic sck_p = 1'b1, cnv_p = 1'b0, done_p = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        sck_p = 1'b1; cnv_p = 1'b0; done_p = 1'b0; sdo_r = 1'b0;
      end else begin
        if (cnv_o && !cnv_p) begin
          chk(sck_o == 1'b1, "R1 sck high at start rise", sck_o, 1);
          chk(err_o == 1'b0, "R8 err cleared by accepted start", err_o, 0);
          conv_timer  = respond ? CONV_LAT : -1;
          marker_seen = 0;
          fall_cnt = 0; cnv_len = 0; rise_cnt++;
        end
        if (cnv_o) cnv_len++;
        if (cnv_o && conv_timer > 0) begin
          conv_timer--;
          if (conv_timer == 0) begin sdo_r = 1'b1; marker_seen = 1; end
        end
        if (!sck_o && sck_p) begin
          fall_cnt++;
          if (fall_cnt == 1)
            chk(marker_seen, "R3 no clock before marker", fall_cnt, 0);
          sdo_r = (q_bits.size() > 0) ? q_bits.pop_front() : 1'b0;
        end
        if (!cnv_o) sdo_r = 1'b0;
        if (sck_o != sck_p) begin
          if (!sck_p)
            chk(run_len == CLK_DIV, "R4 low phase length", run_len, CLK_DIV);
          else if (fall_cnt >= 2)
            chk(run_len == CLK_DIV, "R4 high phase length", run_len, CLK_DIV);
          run_len = 1;
        end else begin
          run_len++;
        end
        chk(sck_o || cnv_o, "R2 sck low only with cnv high", {sck_o, cnv_o}, 2'b11);
        if (done_o) begin
          done_cnt++;
          chk(!done_p, "R6 done single cycle", done_p, 0);
          chk(!cnv_o && cnv_p, "R6 cnv falls with done", {cnv_p, cnv_o}, 2'b10);
          chk(sck_o, "R6 sck high at done", sck_o, 1);
          chk(fall_cnt == PULSES, "R4 falling edge count", fall_cnt, PULSES);
          chk(words_o == exp_words, "R5 words", 64'(words_o), 64'(exp_words));
          chk(!expect_tmo, "R8 no done on timeout", done_o, 0);
        end
        if (!cnv_o && cnv_p && !done_o) begin
          tmo_cnt++;
          chk(expect_tmo, "R2 cnv held until end", cnv_len, 0);
          chk(err_o, "R8 err with cnv fall", err_o, 1);
          chk(cnv_len == TIMEOUT_CYC, "R8 timeout window", cnv_len, TIMEOUT_CYC);
        end
        sck_p = sck_o; cnv_p = cnv_o; done_p = done_o;
      end
    end
  end

  task automatic load_words(input int pat);
    for (int k = 0; k < NUM_DEV; k++) begin
      case (pat)
        0: exp_words[k*WORD_W +: WORD_W] = '0;
        1: exp_words[k*WORD_W +: WORD_W] = '1;
        2: exp_words[k*WORD_W +: WORD_W] = (k % 2 == 0) ? WORD_W'(18'h2AAAA) : WORD_W'(18'h15555);
        3: exp_words[k*WORD_W +: WORD_W] = WORD_W'(k + 1) << (k * 4);
        default: exp_words[k*WORD_W +: WORD_W] = WORD_W'($urandom);
      endcase
    end
    q_bits.delete();
    for (int k = 0; k < NUM_DEV; k++)
      for (int b = WORD_W - 1; b >= 0; b--)
        q_bits.push_back(exp_words[k*WORD_W + b]);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    while (done_cnt == prev) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input int pat);
    int prev;
    load_words(pat);
    respond = 1; expect_tmo = 0;
    prev = done_cnt;
    pulse_start();
    wait_done(prev);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", done_cnt, -1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int prev, rises;
    logic [DATA_BITS-1:0] held;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cnv_o == 1'b0, "R9 reset cnv low", cnv_o, 0);
    chk(sck_o == 1'b1, "R9 reset sck high", sck_o, 1);
    chk(done_o == 1'b0, "R9 reset done low", done_o, 0);
    chk(err_o == 1'b0, "R9 reset err low", err_o, 0);
    chk(words_o == '0, "R9 reset words zero", 64'(words_o), 0);

    for (int p = 0; p < 8; p++) begin
      xfer(p);
      repeat (5) @(negedge clk);
    end

    // R7: start pulses during the wait and during the burst are ignored
    load_words(9);
    respond = 1; expect_tmo = 0;
    prev = done_cnt; rises = rise_cnt;
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    while (fall_cnt < 10) @(negedge clk);
    pulse_start();
    wait_done(prev);
    held = words_o;
    repeat (30) @(negedge clk);
    chk(rise_cnt == rises + 1, "R7 start ignored while busy", rise_cnt, rises + 1);
    chk(cnv_o == 1'b0, "R7 no restart after done", cnv_o, 0);
    chk(words_o == held, "R6 words held after done", 64'(words_o), 64'(held));

    // R8: no marker -> timeout
    respond = 0; expect_tmo = 1; q_bits.delete();
    prev = tmo_cnt;
    rises = done_cnt;
    pulse_start();
    while (tmo_cnt == prev) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(err_o == 1'b1, "R8 err sticky", err_o, 1);
    chk(done_cnt == rises, "R8 no done strobe", done_cnt, rises);
    chk(words_o == held, "R8 words untouched by timeout", 64'(words_o), 64'(held));

    // Recovery after timeout
    xfer(10);
    chk(err_o == 1'b0, "R8 err clear after next start", err_o, 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule